// File: doc/BRIEF.md
# Lane-Group Memory Access Coalescer

This block sits between a group of sixteen execution lanes and the memory pipeline. Each request carries, for every lane, an enable bit and a byte address, plus one shared element size and a load/store flag. The block works out whether all enabled lanes fall, one element each and in lane order, inside a single naturally aligned region of sixteen elements. When they do, the whole group goes out as one wide transaction. When they do not, the block issues one narrow transaction per enabled lane, lowest lane first.

Requests enter on a valid/ready handshake and transactions leave on a second valid/ready handshake. The request side is held off for as long as the transactions of the previous request are still draining. Four event counters record how many non-empty loads and stores were merged and how many were split, so that software tuning the access pattern can see how often a pattern fails to merge.

Top module: `hwc_coalescer`

## Requirements
- R1: After reset `req_ready` is 1, `txn_valid` is 0 and all four event counters are 0.
- R2: With element size 4, 8 or 16 bytes, if every enabled lane k addresses `B + k*size` and B is a multiple of 16*size, exactly one transaction is issued with `txn_addr`=B, `txn_bytes`=16*size, `txn_wide`=1 and `txn_lane`=0.
- R3: If the implied base B is not a multiple of 16*size, the request is split even when every lane follows the lane-to-element mapping.
- R4: If any enabled lane addresses something other than `B + k*size` (a permuted or broadcast pattern), the request is split.
- R5: Disabled lanes never prevent merging, whatever address they carry, and never produce a transaction.
- R6: An element size other than 4, 8 or 16 (for example 12 or 2) always leads to a split request.
- R7: A split request issues one transaction per enabled lane in ascending lane order, each with that lane's address, `txn_bytes` equal to the element size, `txn_wide`=0 and `txn_lane` equal to the lane index.
- R8: `req_ready` is 0 from the cycle after a non-empty request is accepted until the cycle after its last transaction is accepted; a transaction whose `txn_ready` is low keeps its outputs unchanged.
- R9: A request with no enabled lane is accepted in one cycle, issues no transaction, changes no counter and leaves `req_ready` at 1.
- R10: Each non-empty request adds exactly one to one counter chosen by its load/store flag and its merged/split outcome, and every one of its transactions carries the request's store flag on `txn_store`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when valid is also high |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_esize | input | SZ_W | Element size in bytes |
| req_active | input | LANES | Per-lane enable |
| req_addr | input | LANES*ADDR_W | Per-lane byte address, lane k in bits [k*ADDR_W +: ADDR_W] |
| txn_valid | output | 1 | Transaction present |
| txn_ready | input | 1 | Transaction accepted when valid is also high |
| txn_addr | output | ADDR_W | Transaction byte address |
| txn_bytes | output | SZ_W+log2(LANES) | Transaction length in bytes |
| txn_lane | output | log2(LANES) | Lane served (0 for a merged transaction) |
| txn_wide | output | 1 | 1 for a merged transaction |
| txn_store | output | 1 | Store flag of the owning request |
| cnt_ld_merge | output | CNT_W | Merged load count |
| cnt_ld_split | output | CNT_W | Split load count |
| cnt_st_merge | output | CNT_W | Merged store count |
| cnt_st_split | output | CNT_W | Split store count |

## Verification
Every element size from the legal set and two illegal sizes is driven with the same family of lane patterns: linear and aligned with all lanes on, sparse masks with junk on the disabled lanes, a base shifted off the region boundary, two swapped lanes, all lanes on one address, a lone lane whose implied base is aligned or not, and an empty mask. The linear and sparse patterns separate correct merging from over-eager splitting, while the shifted, swapped and broadcast patterns each isolate one of the alignment or mapping tests. The illegal sizes show that size alone forces a split, and a pseudo-random stall pattern on `txn_ready` exercises ordering and holding during drain.

// File: rtl/hwc_pkg.sv
package hwc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WIDE  = 2'd1,
      ST_SPLIT = 2'd2
   } hwc_state_e;

   // Element sizes that may be merged: 4, 8 and 16 bytes.
   function automatic logic size_mergeable(input logic [7:0] sz);
      return (sz == 8'd4) || (sz == 8'd8) || (sz == 8'd16);
   endfunction

   // log2 of a mergeable element size, 0 otherwise.
   function automatic logic [2:0] size_log2(input logic [7:0] sz);
      logic [2:0] r;
      case (sz)
         8'd4:    r = 3'd2;
         8'd8:    r = 3'd3;
         8'd16:   r = 3'd4;
         default: r = 3'd0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/hwc_lane_pick.sv
module hwc_lane_pick #(
   parameter int LANES = 16
) (
   input  logic [LANES-1:0]         mask,
   output logic [$clog2(LANES)-1:0] idx,
   output logic                     any
);
   localparam int IDX_W = $clog2(LANES);

   generate
      if (LANES < 2) begin : g_bad_lanes
         $error("hwc_lane_pick needs at least two lanes");
      end
   endgenerate

   // Lowest set bit wins: scan downward so the last hit is the lowest.
   always_comb begin
      idx = '0;
      any = 1'b0;
      for (int k = LANES - 1; k >= 0; k--) begin
         if (mask[k]) begin
            idx = IDX_W'(k);
            any = 1'b1;
         end
      end
   end

endmodule

// File: rtl/hwc_group_judge.sv
module hwc_group_judge
   import hwc_pkg::*;
#(
   parameter int LANES  = 16,
   parameter int ADDR_W = 32,
   parameter int SZ_W   = 5
) (
   input  logic [LANES-1:0]        active,
   input  logic [LANES*ADDR_W-1:0] addr_flat,
   input  logic [SZ_W-1:0]         esize,
   output logic                    merge,
   output logic                    any_on,
   output logic [ADDR_W-1:0]       base
);
   localparam int IDX_W = $clog2(LANES);

   logic [IDX_W-1:0]  ref_lane;
   logic [ADDR_W-1:0] lane_addr [LANES];
   logic [LANES-1:0]  lane_ok;
   logic [2:0]        esh;
   logic [3:0]        rsh;
   logic              legal;
   logic [ADDR_W-1:0] region_mask;
   logic [ADDR_W-1:0] ref_addr;

   generate
      if (SZ_W > 8) begin : g_bad_szw
         $error("hwc_group_judge supports element size fields up to 8 bits");
      end
      if (ADDR_W < 12) begin : g_bad_aw
         $error("hwc_group_judge needs at least 12 address bits");
      end
   endgenerate

   hwc_lane_pick #(.LANES(LANES)) u_ref_pick (
      .mask (active),
      .idx  (ref_lane),
      .any  (any_on)
   );

   assign legal       = size_mergeable(8'(esize));
   assign esh         = size_log2(8'(esize));
   assign rsh         = 4'(esh) + 4'(IDX_W);
   assign region_mask = ~({ADDR_W{1'b1}} << rsh);
   assign ref_addr    = lane_addr[ref_lane];
   assign base        = ref_addr - (ADDR_W'(ref_lane) << esh);

   // Per-lane mapping test: lane k must point at element k of the region.
   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         assign lane_addr[k] = addr_flat[k*ADDR_W +: ADDR_W];
         assign lane_ok[k]   = !active[k] ||
                               (lane_addr[k] == base + (ADDR_W'(k) << esh));
      end
   endgenerate

   assign merge = legal && any_on && ((base & region_mask) == '0) && (&lane_ok);

endmodule

// File: rtl/hwc_event_counters.sv
module hwc_event_counters #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_fire,
   input  logic             ev_store,
   input  logic             ev_merge,
   output logic [CNT_W-1:0] ld_merge,
   output logic [CNT_W-1:0] ld_split,
   output logic [CNT_W-1:0] st_merge,
   output logic [CNT_W-1:0] st_split
);
   localparam int NCNT = 4;

   logic [CNT_W-1:0] cnt_q [NCNT];
   logic [1:0]       sel;

   generate
      if (CNT_W < 2) begin : g_bad_cw
         $error("hwc_event_counters needs counters of two bits or more");
      end
   endgenerate

   // Slot: bit1 = store, bit0 = split.
   assign sel = {ev_store, !ev_merge};

   generate
      for (genvar i = 0; i < NCNT; i++) begin : g_cnt
         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt_q[i] <= '0;
            else if (ev_fire && (sel == 2'(i)))
               cnt_q[i] <= cnt_q[i] + 1'b1;
         end

         // R10
         cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q[i] == $past(cnt_q[i])) || (cnt_q[i] == $past(cnt_q[i]) + 1'b1));
      end
   endgenerate

   assign ld_merge = cnt_q[0];
   assign ld_split = cnt_q[1];
   assign st_merge = cnt_q[2];
   assign st_split = cnt_q[3];

endmodule

// File: rtl/hwc_coalescer.sv
module hwc_coalescer
   import hwc_pkg::*;
#(
   parameter int LANES  = 16,
   parameter int ADDR_W = 32,
   parameter int SZ_W   = 5,
   parameter int CNT_W  = 16
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            req_valid,
   output logic                            req_ready,
   input  logic                            req_store,
   input  logic [SZ_W-1:0]                 req_esize,
   input  logic [LANES-1:0]                req_active,
   input  logic [LANES*ADDR_W-1:0]         req_addr,
   output logic                            txn_valid,
   input  logic                            txn_ready,
   output logic [ADDR_W-1:0]               txn_addr,
   output logic [SZ_W+$clog2(LANES)-1:0]   txn_bytes,
   output logic [$clog2(LANES)-1:0]        txn_lane,
   output logic                            txn_wide,
   output logic                            txn_store,
   output logic [CNT_W-1:0]                cnt_ld_merge,
   output logic [CNT_W-1:0]                cnt_ld_split,
   output logic [CNT_W-1:0]                cnt_st_merge,
   output logic [CNT_W-1:0]                cnt_st_split
);
   localparam int IDX_W   = $clog2(LANES);
   localparam int BYTES_W = SZ_W + IDX_W;

   generate
      if ((LANES & (LANES - 1)) != 0) begin : g_bad_pow2
         $error("hwc_coalescer needs a power-of-two lane count");
      end
   endgenerate

   hwc_state_e        state_q;
   logic [LANES-1:0]  pend_q;
   logic [LANES-1:0]  pend_nxt;
   logic [ADDR_W-1:0] addr_q [LANES];
   logic [ADDR_W-1:0] base_q;
   logic [SZ_W-1:0]   esize_q;
   logic              store_q;

   logic              j_merge;
   logic              j_any;
   logic [ADDR_W-1:0] j_base;
   logic [IDX_W-1:0]  cur_lane;
   logic              cur_any;
   logic              accept;
   logic              txn_fire;

   hwc_group_judge #(
      .LANES  (LANES),
      .ADDR_W (ADDR_W),
      .SZ_W   (SZ_W)
   ) u_judge (
      .active    (req_active),
      .addr_flat (req_addr),
      .esize     (req_esize),
      .merge     (j_merge),
      .any_on    (j_any),
      .base      (j_base)
   );

   hwc_lane_pick #(.LANES(LANES)) u_issue_pick (
      .mask (pend_q),
      .idx  (cur_lane),
      .any  (cur_any)
   );

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign txn_valid = (state_q != ST_IDLE);
   assign txn_fire  = txn_valid && txn_ready;
   assign pend_nxt  = pend_q & ~(LANES'(1) << cur_lane);

   // Control.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pend_q  <= '0;
         base_q  <= '0;
         esize_q <= '0;
         store_q <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (accept && j_any) begin
                  state_q <= j_merge ? ST_WIDE : ST_SPLIT;
                  pend_q  <= req_active;
                  base_q  <= j_base;
                  esize_q <= req_esize;
                  store_q <= req_store;
               end
            end
            ST_WIDE: begin
               if (txn_fire) begin
                  state_q <= ST_IDLE;
                  pend_q  <= '0;
               end
            end
            ST_SPLIT: begin
               if (txn_fire) begin
                  pend_q <= pend_nxt;
                  if (pend_nxt == '0) state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // Per-lane address capture.
   generate
      for (genvar k = 0; k < LANES; k++) begin : g_cap
         always_ff @(posedge clk) begin
            if (!rst_n)
               addr_q[k] <= '0;
            else if (accept && j_any)
               addr_q[k] <= req_addr[k*ADDR_W +: ADDR_W];
         end
      end
   endgenerate

   // Transaction outputs.
   always_comb begin
      txn_store = store_q;
      if (state_q == ST_WIDE) begin
         txn_addr  = base_q;
         txn_bytes = BYTES_W'(esize_q) << IDX_W;
         txn_lane  = '0;
         txn_wide  = 1'b1;
      end else begin
         txn_addr  = addr_q[cur_lane];
         txn_bytes = BYTES_W'(esize_q);
         txn_lane  = cur_lane;
         txn_wide  = 1'b0;
      end
   end

   hwc_event_counters #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_fire  (accept && j_any),
      .ev_store (req_store),
      .ev_merge (j_merge),
      .ld_merge (cnt_ld_merge),
      .ld_split (cnt_ld_split),
      .st_merge (cnt_st_merge),
      .st_split (cnt_st_split)
   );

   // R8
   busy_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |-> !req_ready);

   // R8
   txn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && !txn_ready) |=>
         (txn_valid && $stable(txn_addr) && $stable(txn_lane) && $stable(txn_wide)));

   // R2
   wide_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && txn_wide) |-> ((txn_addr & (ADDR_W'(txn_bytes) - 1'b1)) == '0));

   // R7
   split_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_fire && !txn_wide) |=> (!txn_valid || (txn_lane > $past(txn_lane))));

   // R7
   split_has_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && !txn_wide) |-> cur_any);

   // R9
   empty_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && (req_active == '0)) |=> (req_ready && !txn_valid));

endmodule

// File: tb/hwc_coalescer_tb_top.sv
module hwc_coalescer_tb_top;
   localparam int LANES  = 16;
   localparam int ADDR_W = 32;
   localparam int SZ_W   = 5;
   localparam int CNT_W  = 16;

   logic                      clk = 1'b0;
   logic                      rst_n = 1'b0;
   logic                      req_valid = 1'b0;
   logic                      req_ready;
   logic                      req_store = 1'b0;
   logic [SZ_W-1:0]           req_esize = '0;
   logic [LANES-1:0]          req_active = '0;
   logic [LANES*ADDR_W-1:0]   req_addr = '0;
   logic                      txn_valid;
   logic                      txn_ready = 1'b0;
   logic [ADDR_W-1:0]         txn_addr;
   logic [SZ_W+3:0]           txn_bytes;
   logic [3:0]                txn_lane;
   logic                      txn_wide;
   logic                      txn_store;
   logic [CNT_W-1:0]          c_lm, c_ls, c_sm, c_ss;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   logic [31:0] a [LANES];
   int exp_n;
   logic [31:0] e_addr [LANES];
   int          e_bytes [LANES];
   int          e_lane [LANES];
   bit          e_wide [LANES];
   int m_lm = 0, m_ls = 0, m_sm = 0, m_ss = 0;
   logic [7:0] lfsr = 8'h5B;

   always #2 clk = ~clk;

   hwc_coalescer #(
      .LANES(LANES), .ADDR_W(ADDR_W), .SZ_W(SZ_W), .CNT_W(CNT_W)
   ) dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
      .req_esize(req_esize), .req_active(req_active), .req_addr(req_addr),
      .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_addr(txn_addr),
      .txn_bytes(txn_bytes), .txn_lane(txn_lane), .txn_wide(txn_wide),
      .txn_store(txn_store),
      .cnt_ld_merge(c_lm), .cnt_ld_split(c_ls),
      .cnt_st_merge(c_sm), .cnt_st_split(c_ss)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Bench model: reference lane is the highest enabled lane.
   task automatic build_expect(input int sz, input logic [LANES-1:0] m, output bit merged);
      int h;
      logic [31:0] b;
      bit ok;
      h = -1;
      for (int k = 0; k < LANES; k++) if (m[k]) h = k;
      exp_n = 0;
      merged = 0;
      if (h < 0) return;
      b = a[h] - 32'(h * sz);
      ok = (sz == 4 || sz == 8 || sz == 16) && ((b % (16 * sz)) == 0);
      for (int k = 0; k < LANES; k++)
         if (m[k] && a[k] != b + 32'(k * sz)) ok = 0;
      if (ok) begin
         merged = 1;
         exp_n = 1;
         e_addr[0] = b; e_bytes[0] = 16 * sz; e_lane[0] = 0; e_wide[0] = 1;
      end else begin
         for (int k = 0; k < LANES; k++) if (m[k]) begin
            e_addr[exp_n] = a[k]; e_bytes[exp_n] = sz;
            e_lane[exp_n] = k;    e_wide[exp_n] = 0;
            exp_n++;
         end
      end
   endtask

   task automatic run_req(input bit st, input int sz, input logic [LANES-1:0] m,
                          input string req);
      bit merged;
      int got;
      int guard;
      build_expect(sz, m, merged);
      for (int k = 0; k < LANES; k++) req_addr[k*ADDR_W +: ADDR_W] = a[k];
      req_store  = st;
      req_esize  = SZ_W'(sz);
      req_active = m;
      req_valid  = 1'b1;
      chk(req_ready === 1'b1, "R8", "ready before request", req_ready, 1);
      @(negedge clk);
      req_valid = 1'b0;
      if (m != 0) begin
         if (merged) begin if (st) m_sm++; else m_lm++; end
         else        begin if (st) m_ss++; else m_ls++; end
      end
      got = 0;
      guard = 0;
      while (!(req_ready && !txn_valid)) begin
         chk(req_ready === 1'b0, "R8", "ready while draining", req_ready, 0);
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         txn_ready = lfsr[0] | lfsr[3];
         if (txn_valid && txn_ready) begin
            if (got < exp_n) begin
               chk(txn_addr == e_addr[got], merged ? "R2" : "R7", "txn address",
                   txn_addr, e_addr[got]);
               chk(int'(txn_bytes) == e_bytes[got], merged ? "R2" : "R6", "txn bytes",
                   txn_bytes, e_bytes[got]);
               chk(int'(txn_lane) == e_lane[got] && txn_wide == e_wide[got], req,
                   "txn lane/wide", {txn_wide, txn_lane}, {e_wide[got], 4'(e_lane[got])});
               chk(txn_store == st, "R10", "txn store flag", txn_store, st);
            end
            got++;
         end
         @(negedge clk);
         guard++;
         if (guard > 400) begin
            chk(0, "R8", "drain timeout", guard, exp_n);
            break;
         end
      end
      txn_ready = 1'b0;
      chk(got == exp_n, m == 0 ? "R9" : req, "transaction count", got, exp_n);
      chk(c_lm == CNT_W'(m_lm) && c_ls == CNT_W'(m_ls) &&
          c_sm == CNT_W'(m_sm) && c_ss == CNT_W'(m_ss), "R10", "counters",
          {c_lm, c_ls, c_sm, c_ss},
          {CNT_W'(m_lm), CNT_W'(m_ls), CNT_W'(m_sm), CNT_W'(m_ss)});
   endtask

   task automatic fill(input logic [31:0] b, input int sz, input logic [LANES-1:0] m);
      for (int k = 0; k < LANES; k++)
         a[k] = m[k] ? b + 32'(k * sz) : 32'hDEAD_0000 + 32'(k * 7);
   endtask

   initial begin
      int sizes [5];
      bit st;
      sizes[0] = 4; sizes[1] = 8; sizes[2] = 16; sizes[3] = 12; sizes[4] = 2;
      st = 0;
      repeat (3) @(negedge clk);
      chk(req_ready === 1'b1 && txn_valid === 1'b0, "R1", "ready/valid in reset",
          {req_ready, txn_valid}, 2'b10);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready === 1'b1 && txn_valid === 1'b0, "R1", "ready/valid after reset",
          {req_ready, txn_valid}, 2'b10);
      chk(c_lm == 0 && c_ls == 0 && c_sm == 0 && c_ss == 0, "R1", "counters after reset",
          {c_lm, c_ls, c_sm, c_ss}, 0);
      for (int s = 0; s < 5; s++) begin
         int sz;
         sz = sizes[s];
         // R2 / R6: linear aligned, all lanes
         fill(32'h1000, sz, 16'hFFFF); run_req(st, sz, 16'hFFFF, sz == 4 || sz == 8 || sz == 16 ? "R2" : "R6"); st = !st;
         // R5: sparse mask, junk on disabled lanes
         fill(32'h2000, sz, 16'hA5A4); run_req(st, sz, 16'hA5A4, "R5"); st = !st;
         fill(32'h2800, sz, 16'hFFFE); run_req(st, sz, 16'hFFFE, "R5"); st = !st;
         // R3: base shifted off region boundary
         fill(32'h3000 + 32'(sz), sz, 16'hFFFF); run_req(st, sz, 16'hFFFF, "R3"); st = !st;
         // R4: swapped lanes
         fill(32'h1000, sz, 16'hFFFF);
         a[1] = 32'h1000 + 32'(2 * sz); a[2] = 32'h1000 + 32'(sz);
         run_req(st, sz, 16'hFFFF, "R4"); st = !st;
         // R4: broadcast
         for (int k = 0; k < LANES; k++) a[k] = 32'h5000;
         run_req(st, sz, 16'hFFFF, "R4"); st = !st;
         // R5 / R3: lone lane, aligned and misaligned implied base
         fill(32'h4000, sz, 16'h0020); run_req(st, sz, 16'h0020, "R5"); st = !st;
         fill(32'h4004, sz, 16'h0020); run_req(st, sz, 16'h0020, "R3"); st = !st;
         // R9: empty request
         fill(32'h6000, sz, 16'h0000); run_req(st, sz, 16'h0000, "R9"); st = !st;
         chk(req_ready === 1'b1 && txn_valid === 1'b0, "R9", "idle after empty",
             {req_ready, txn_valid}, 2'b10);
      end
      if (!done) begin
         done = 1;
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule